// File: doc/BRIEF.md
# Battery-Backed SRAM Access Gate

This block sits between a host bus and a battery-backed static RAM array and decides, cycle by cycle, whether a host access may reach the array. It takes the active-low chip-enable, write-enable and output-enable from the host and passes them through two flip-flops. From these synchronised copies it derives an internal read enable, an internal write strobe and the enable for the data output drivers. All three stay low while the supply-good flag is low, so the array cannot be written or read during a brown-out.

When the supply returns, the block waits through a recovery interval of `RECOV_CYC` clocks. During that interval chip-enable is ignored. At the moment of return it also samples two battery-ok flags. If both batteries report low, the block suppresses the second memory cycle after recovery, with no write strobe and no output drive for that cycle. Software can detect the condition by writing a location and reading it back. Memory cycles are counted by chip-enable assertions after recovery, and the count saturates at two.

Top module: `sram_access_gate`

## Requirements
- R1: While `supply_ok` is low, `rd_en`, `wr_stb` and `drv_en` are all 0, whatever the control inputs do.
- R2: When the gate is ready, chip-enable low with write-enable high gives `rd_en` = 1. `drv_en` is 1 only when output-enable is also low.
- R3: `wr_stb` is 1 exactly while chip-enable and write-enable are both low. It begins at the later of the two falling edges and ends at the earlier of the two rising edges.
- R4: If write-enable falls while the output drivers are on, `drv_en` drops to 0 and `wr_stb` rises at the same clock.
- R5: After `supply_ok` rises, chip-enable is ignored for `RECOV_CYC` clocks: no output is asserted and no memory cycle is counted.
- R6: The battery flags are sampled on the clock where `supply_ok` rises. If both are 0, the second memory cycle after recovery asserts neither `rd_en`, `wr_stb` nor `drv_en`. The first and third cycles act normally.
- R7: If only one battery flag is 0 at restore, no cycle is suppressed.
- R8: Every supply restore re-samples the batteries and restarts the cycle count. Battery flags that change after the restore have no effect.
- R9: A change on a control input reaches the outputs after exactly two rising clock edges.
- R10: While `rst_n` is low, and directly after it is released, all outputs are 0. The gate then behaves as if the supply were off, so a `supply_ok` that is already high is treated as a fresh restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above the operating threshold |
| batt_a_ok | input | 1 | First backup battery above the warning threshold |
| batt_b_ok | input | 1 | Second backup battery above the warning threshold |
| ce_n | input | 1 | Host chip-enable, active low |
| we_n | input | 1 | Host write-enable, active low |
| oe_n | input | 1 | Host output-enable, active low |
| rd_en | output | 1 | Internal read enable to the array |
| wr_stb | output | 1 | Internal write strobe to the array |
| drv_en | output | 1 | Data output driver enable |

## Verification
The gate is driven with reads where output-enable is held high and where it is low. It is also driven with writes in both edge orders of chip-enable and write-enable, and with write-enable falling in the middle of a driven read. Together these separate the read path, the driver path and the overlap strobe. Supply restores are tried with both batteries low, with one battery low, and with both good followed by a later fall of the battery flags. Comparing which of the first three cycles is suppressed shows whether the battery sample, the cycle count and the restart on restore each behave as required. A chip-enable pulse placed inside the recovery window shows that such a pulse neither reaches the array nor advances the count.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int unsigned CTL_W  = 3;
  localparam int unsigned CTL_CE = 0;
  localparam int unsigned CTL_WE = 1;
  localparam int unsigned CTL_OE = 2;
  localparam int unsigned CYC_W  = 2;
  localparam logic [CYC_W-1:0] CYC_SAT = 2'd2;
  localparam logic [CYC_W-1:0] CYC_BLK = 2'd1;
endpackage

// File: rtl/sag_ctl_sync.sv
module sag_ctl_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_n,
  output logic [WIDTH-1:0] sync_n
);
  logic [WIDTH-1:0] stg_q [STAGES];

  // Active-low controls reset to their inactive level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '1;
    else        stg_q[0] <= raw_n;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '1;
      else        stg_q[g] <= stg_q[g-1];
    end
  end

  assign sync_n = stg_q[STAGES-1];
endmodule

// File: rtl/sag_power_seq.sv
module sag_power_seq
  import sag_pkg::*;
#(
  parameter int unsigned RECOV_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic batt_a_ok,
  input  logic batt_b_ok,
  input  logic s_ce_n,
  output logic live,
  output logic blk_now
);
  localparam int unsigned CW = $clog2(RECOV_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(RECOV_CYC);

  logic             sup_q, sup_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             low_q, low_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             blk_q, blk_d;
  logic             live_q;
  logic             ready, start;

  assign ready   = supply_ok && sup_q && (cnt_q == '0);
  assign live    = ready && !s_ce_n;
  assign start   = live && !live_q;
  assign blk_now = start ? (low_q && (cyc_q == CYC_BLK)) : blk_q;

  always_comb begin
    sup_d = supply_ok;
    cnt_d = cnt_q;
    low_d = low_q;
    cyc_d = cyc_q;
    blk_d = blk_q;
    if (!supply_ok) begin
      cnt_d = '0;
      cyc_d = '0;
      blk_d = 1'b0;
    end else if (!sup_q) begin
      // Supply has just returned: sample the batteries and start recovery.
      cnt_d = CNT_LOAD;
      low_d = !batt_a_ok && !batt_b_ok;
      cyc_d = '0;
      blk_d = 1'b0;
    end else begin
      if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
      if (start && (cyc_q != CYC_SAT)) cyc_d = cyc_q + CYC_W'(1);
      blk_d = live ? blk_now : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q  <= 1'b0;
      cnt_q  <= '0;
      low_q  <= 1'b0;
      cyc_q  <= '0;
      blk_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      sup_q  <= sup_d;
      cnt_q  <= cnt_d;
      low_q  <= low_d;
      cyc_q  <= cyc_d;
      blk_q  <= blk_d;
      live_q <= live;
    end
  end

  // R5: no access is live while recovery is still counting down
  a_r5_no_live_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> !live);
  // R6: the cycle count never passes its saturation value
  a_r6_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= CYC_SAT);
  // R8: a restore restarts the count from zero
  a_r8_restore_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_q) |-> (cyc_q == '0) && !blk_q);
endmodule

// File: rtl/sag_access_decode.sv
module sag_access_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic blk_now,
  input  logic s_we_n,
  input  logic s_oe_n,
  output logic rd_en,
  output logic wr_stb,
  output logic drv_en
);
  logic pass;

  always_comb begin
    pass   = live && !blk_now;
    rd_en  = pass && s_we_n;
    wr_stb = pass && !s_we_n;
    drv_en = rd_en && !s_oe_n;
  end

  // R2: the drivers are only on during a read
  a_r2_drv_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> rd_en);
  // R3: read and write strobes never overlap
  a_r3_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_stb));
  // R4: a write strobe never coincides with driven outputs
  a_r4_no_drv_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !drv_en);
endmodule

// File: rtl/sram_access_gate.sv
module sram_access_gate
  import sag_pkg::*;
#(
  parameter int unsigned RECOV_CYC   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic batt_a_ok,
  input  logic batt_b_ok,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic rd_en,
  output logic wr_stb,
  output logic drv_en
);
  logic [CTL_W-1:0] raw_n, sync_n;
  logic live, blk_now;

  always_comb begin
    raw_n         = '1;
    raw_n[CTL_CE] = ce_n;
    raw_n[CTL_WE] = we_n;
    raw_n[CTL_OE] = oe_n;
  end

  sag_ctl_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_n(raw_n), .sync_n(sync_n)
  );

  sag_power_seq #(.RECOV_CYC(RECOV_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .batt_a_ok(batt_a_ok), .batt_b_ok(batt_b_ok),
    .s_ce_n(sync_n[CTL_CE]), .live(live), .blk_now(blk_now)
  );

  sag_access_decode u_dec (
    .clk(clk), .rst_n(rst_n), .live(live), .blk_now(blk_now),
    .s_we_n(sync_n[CTL_WE]), .s_oe_n(sync_n[CTL_OE]),
    .rd_en(rd_en), .wr_stb(wr_stb), .drv_en(drv_en)
  );

  // R1: nothing reaches the array while the supply is low
  a_r1_supply_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !rd_en && !wr_stb && !drv_en);
endmodule

// File: tb/tb_sram_access_gate.sv
`timescale 1ns/1ps
module tb_sram_access_gate;
  localparam int RECOV = 16;

  logic clk = 1'b0;
  logic rst_n, supply_ok, batt_a_ok, batt_b_ok, ce_n, we_n, oe_n;
  logic rd_en, wr_stb, drv_en;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sram_access_gate #(.RECOV_CYC(RECOV)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .batt_a_ok(batt_a_ok), .batt_b_ok(batt_b_ok),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .rd_en(rd_en), .wr_stb(wr_stb), .drv_en(drv_en)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic ce, input logic we, input logic oe);
    ce_n = ce; we_n = we; oe_n = oe;
    cyc(3);
  endtask

  task automatic power_up(input logic a, input logic b);
    batt_a_ok = a; batt_b_ok = b;
    supply_ok = 1'b1;
    cyc(RECOV + 4);
  endtask

  task automatic power_down();
    drive(1, 1, 1);
    supply_ok = 1'b0;
    cyc(3);
  endtask

  // One memory cycle, returning what the array saw.
  task automatic mem_cycle(input logic we, output logic r, output logic w, output logic d);
    drive(0, we, 0);
    r = rd_en; w = wr_stb; d = drv_en;
    drive(1, 1, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; supply_ok = 1'b1; batt_a_ok = 1'b1; batt_b_ok = 1'b1;
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    cyc(3);
    chk("R10", "rd_en in reset", rd_en, 1'b0);
    chk("R10", "drv_en in reset", drv_en, 1'b0);
    rst_n = 1'b1;
    cyc(3);
    chk("R10", "rd_en after release (treated as restore)", rd_en, 1'b0);
    ce_n = 1'b1;
    cyc(RECOV + 4);
  endtask

  task automatic t_latency();
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9", "rd_en after one edge", rd_en, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R9", "rd_en after two edges", rd_en, 1'b1);
    drive(1, 1, 1);
  endtask

  task automatic t_read_write();
    drive(0, 1, 1);
    chk("R2", "rd_en with OE high", rd_en, 1'b1);
    chk("R2", "drv_en with OE high", drv_en, 1'b0);
    drive(0, 1, 0);
    chk("R2", "drv_en with OE low", drv_en, 1'b1);
    drive(0, 0, 0);
    chk("R4", "drv_en after WE falls", drv_en, 1'b0);
    chk("R4", "wr_stb after WE falls", wr_stb, 1'b1);
    drive(1, 1, 1);
    drive(1, 0, 1);
    chk("R3", "wr_stb with WE low only", wr_stb, 1'b0);
    drive(0, 0, 1);
    chk("R3", "wr_stb at later CE fall", wr_stb, 1'b1);
    drive(1, 0, 1);
    chk("R3", "wr_stb ends at CE rise", wr_stb, 1'b0);
    drive(1, 1, 1);
  endtask

  task automatic t_supply();
    drive(0, 1, 0);
    chk("R1", "rd_en before drop", rd_en, 1'b1);
    supply_ok = 1'b0;
    #1;
    chk("R1", "rd_en on supply drop", rd_en, 1'b0);
    chk("R1", "drv_en on supply drop", drv_en, 1'b0);
    drive(0, 0, 1);
    chk("R1", "wr_stb while supply low", wr_stb, 1'b0);
    drive(1, 1, 1);
  endtask

  task automatic t_both_low();
    logic r, w, d;
    batt_a_ok = 1'b0; batt_b_ok = 1'b0;
    supply_ok = 1'b1;
    cyc(2);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    cyc(3);
    chk("R5", "rd_en during recovery", rd_en, 1'b0);
    chk("R5", "drv_en during recovery", drv_en, 1'b0);
    ce_n = 1'b1;
    cyc(RECOV);
    mem_cycle(1, r, w, d);
    chk("R6", "first cycle rd_en", r, 1'b1);
    chk("R5", "pulse in recovery not counted (first allowed)", d, 1'b1);
    mem_cycle(1, r, w, d);
    chk("R6", "second cycle rd_en", r, 1'b0);
    chk("R6", "second cycle drv_en", d, 1'b0);
    mem_cycle(0, r, w, d);
    chk("R6", "third cycle wr_stb", w, 1'b1);
    mem_cycle(1, r, w, d);
    chk("R6", "fourth cycle rd_en", r, 1'b1);
  endtask

  task automatic t_one_low();
    logic r, w, d;
    power_up(1'b1, 1'b0);
    mem_cycle(0, r, w, d);
    chk("R7", "first cycle wr_stb", w, 1'b1);
    mem_cycle(0, r, w, d);
    chk("R7", "second cycle wr_stb", w, 1'b1);
  endtask

  task automatic t_restore();
    logic r, w, d;
    power_up(1'b1, 1'b1);
    batt_a_ok = 1'b0; batt_b_ok = 1'b0;
    mem_cycle(1, r, w, d);
    chk("R8", "first cycle after late battery fall", r, 1'b1);
    mem_cycle(1, r, w, d);
    chk("R8", "second cycle after late battery fall", r, 1'b1);
    power_down();
    power_up(1'b0, 1'b0);
    mem_cycle(1, r, w, d);
    chk("R8", "re-sampled restore first cycle", r, 1'b1);
    mem_cycle(1, r, w, d);
    chk("R8", "re-sampled restore second cycle", r, 1'b0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_read_write();
    t_supply();
    t_both_low();
    power_down();
    t_one_low();
    power_down();
    t_restore();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule